// File: doc/BRIEF.md
# NOR Flash Command Interpreter

This block is the device-side command decoder of a parallel NOR flash, modelled one bus cycle per clock. A host drives single-cycle write strobes with an address and a data byte, and single-cycle read strobes with an address. Write cycles are matched against unlock sequences that launch a word program or a whole-array erase. Program can be paused and continued with one-write commands. Operation lengths come from cycle-count parameters. The storage is a small internal word array.

While an embedded operation runs, `ready_o` is low and reads return a status byte instead of array data. Bit 7 shows the complement of the pending data bit 7, bit 6 flips on every status read, and bit 2 flips on every read during an erase. A suspended program lets the host read the other sectors. The asynchronous reset ends any operation at once and leaves the array as it was.

Top module: `norflash_cmd_fsm`

## Requirements
- R1: While `rst_ni` is low, `ready_o` is 1 and `rdata_o` is 0. A reset during an erase aborts it and leaves every array word unchanged.
- R2: The writes AAh@555h, 55h@2AAh, A0h@555h, then any address/data, start a program. `ready_o` is then low for exactly PROG_CYC cycles.
- R3: When a program completes, the addressed word (index = low IDX_W address bits) holds its old value ANDed with the written data.
- R4: The six writes AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h start a chip erase. `ready_o` is then low for exactly ERASE_CYC cycles, after which every word reads FFh.
- R5: A write that does not match the next expected step returns the decoder to read mode. No operation starts, `ready_o` stays 1 and the array is unchanged.
- R6: During a chip erase every write is ignored, B0h included. The erase length and result do not change.
- R7: A status byte has bit 7 = complement of bit 7 of the program data (0 during erase). Bits 6 and 2 are as in R8, and all other bits are 0.
- R8: Bit 6 inverts on each successive status read. Bit 2 inverts on each status read during erase and holds during program.
- R9: Data B0h written at any address during a program stops it. `ready_o` stays low for SUSP_CYC more cycles, then goes high while the program stays unfinished.
- R10: While suspended, reads from the sector (address index bits above SECT_SH) of the word being programmed return the status byte. Reads from any other sector return array data.
- R11: Data 30h while suspended resumes the program. Total low time is PROG_CYC plus SUSP_CYC per suspend. Further 30h writes are ignored, and B0h may suspend again.
- R12: A read strobe sampled at a clock edge has its data on `rdata_o` after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hardware reset |
| we_i | input | 1 | Write strobe, one bus write per cycle high |
| re_i | input | 1 | Read strobe |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | DATA_W | Write data / command byte |
| rdata_o | output | DATA_W | Read data or status byte |
| ready_o | output | 1 | 1 = idle or suspended, 0 = embedded operation running |

## Verification
A read is due on `rdata_o` at the first sample after the edge that took the strobe, and the bench samples it there. The busy time is counted by a monitor that counts every falling edge with `ready_o` low. That count must equal PROG_CYC or ERASE_CYC after a start write, and PROG_CYC plus SUSP_CYC per suspend across a suspend/resume cycle. Ignored or mismatched writes are judged by `ready_o` staying high and by reading back every affected word against a bench model that ANDs program data and fills FFh on erase.

// File: rtl/nfc_pkg.sv
package nfc_pkg;
  typedef enum logic [3:0] {
    ST_READ, ST_U1, ST_U2, ST_PSETUP, ST_ESETUP, ST_EU1, ST_EU2,
    ST_PROG, ST_PSETTLE, ST_PSUSP, ST_ERASE
  } nfc_state_e;

  localparam int unsigned ADR_KEY_A  = 32'h555;
  localparam int unsigned ADR_KEY_B  = 32'h2AA;
  localparam int unsigned CMD_KEY_A  = 32'hAA;
  localparam int unsigned CMD_KEY_B  = 32'h55;
  localparam int unsigned CMD_PROG   = 32'hA0;
  localparam int unsigned CMD_ESETUP = 32'h80;
  localparam int unsigned CMD_CHIP   = 32'h10;
  localparam int unsigned CMD_SUSP   = 32'hB0;
  localparam int unsigned CMD_RESUME = 32'h30;
endpackage

// File: rtl/nfc_cnt.sv
module nfc_cnt #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  input  logic             run_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         cnt_q <= '0;
    else if (load_i)                     cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)       cnt_q <= cnt_q - CNT_W'(1);
  end
endmodule

// File: rtl/nfc_array.sv
module nfc_array #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              erase_all_i,
  input  logic              prog_we_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [DATA_W-1:0] rd_data_o
);
  localparam int WORDS = 1 << IDX_W;

  logic [DATA_W-1:0] mem_q [WORDS];

  // non-volatile model: no reset on the cells
  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk_i) begin
      if (erase_all_i)                             mem_q[g] <= '1;
      else if (prog_we_i && wr_idx_i == IDX_W'(g)) mem_q[g] <= mem_q[g] & wr_data_i;
    end
  end

  assign rd_data_o = mem_q[rd_idx_i];
endmodule

// File: rtl/nfc_ctrl.sv
module nfc_ctrl
  import nfc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 4,
  parameter int CNT_W     = 8,
  parameter int PROG_CYC  = 20,
  parameter int ERASE_CYC = 60,
  parameter int SUSP_CYC  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              op_done_i,
  input  logic              settle_done_i,
  output nfc_state_e        st_o,
  output logic              op_load_o,
  output logic [CNT_W-1:0]  op_len_o,
  output logic              settle_load_o,
  output logic [CNT_W-1:0]  settle_len_o,
  output logic              prog_we_o,
  output logic              erase_all_o,
  output logic [IDX_W-1:0]  tgt_idx_o,
  output logic [DATA_W-1:0] tgt_data_o
);
  localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(ADR_KEY_A);
  localparam logic [ADDR_W-1:0] ADR_B = ADDR_W'(ADR_KEY_B);

  nfc_state_e st_q, st_d;
  logic [IDX_W-1:0]  tgt_idx_q;
  logic [DATA_W-1:0] tgt_data_q;
  logic latch_tgt;

  function automatic logic at(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d,
                              input logic [ADDR_W-1:0] ea, input int unsigned ed);
    return (a == ea) && (d == DATA_W'(ed));
  endfunction

  always_comb begin
    st_d          = st_q;
    op_load_o     = 1'b0;
    op_len_o      = CNT_W'(PROG_CYC);
    settle_load_o = 1'b0;
    prog_we_o     = 1'b0;
    erase_all_o   = 1'b0;
    latch_tgt     = 1'b0;
    unique case (st_q)
      ST_READ:   if (we_i && at(addr_i, wdata_i, ADR_A, CMD_KEY_A)) st_d = ST_U1;
      ST_U1:     if (we_i) st_d = at(addr_i, wdata_i, ADR_B, CMD_KEY_B) ? ST_U2 : ST_READ;
      ST_U2: if (we_i) begin
        if (at(addr_i, wdata_i, ADR_A, CMD_PROG))        st_d = ST_PSETUP;
        else if (at(addr_i, wdata_i, ADR_A, CMD_ESETUP)) st_d = ST_ESETUP;
        else                                             st_d = ST_READ;
      end
      ST_PSETUP: if (we_i) begin
        st_d      = ST_PROG;
        latch_tgt = 1'b1;
        op_load_o = 1'b1;
      end
      ST_ESETUP: if (we_i) st_d = at(addr_i, wdata_i, ADR_A, CMD_KEY_A) ? ST_EU1 : ST_READ;
      ST_EU1:    if (we_i) st_d = at(addr_i, wdata_i, ADR_B, CMD_KEY_B) ? ST_EU2 : ST_READ;
      ST_EU2: if (we_i) begin
        if (at(addr_i, wdata_i, ADR_A, CMD_CHIP)) begin
          st_d      = ST_ERASE;
          op_load_o = 1'b1;
          op_len_o  = CNT_W'(ERASE_CYC);
        end else st_d = ST_READ;
      end
      ST_PROG: begin
        if (op_done_i) begin
          st_d      = ST_READ;
          prog_we_o = 1'b1;
        end else if (we_i && wdata_i == DATA_W'(CMD_SUSP)) begin
          st_d          = ST_PSETTLE;
          settle_load_o = 1'b1;
        end
      end
      ST_PSETTLE: if (settle_done_i) st_d = ST_PSUSP;
      ST_PSUSP:   if (we_i && wdata_i == DATA_W'(CMD_RESUME)) st_d = ST_PROG;
      ST_ERASE: if (op_done_i) begin  // writes ignored until done
        st_d        = ST_READ;
        erase_all_o = 1'b1;
      end
      default: st_d = ST_READ;
    endcase
  end

  assign settle_len_o = CNT_W'(SUSP_CYC);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_READ;
      tgt_idx_q  <= '0;
      tgt_data_q <= '0;
    end else begin
      st_q <= st_d;
      if (latch_tgt) begin
        tgt_idx_q  <= addr_i[IDX_W-1:0];
        tgt_data_q <= wdata_i;
      end
    end
  end

  assign st_o       = st_q;
  assign tgt_idx_o  = tgt_idx_q;
  assign tgt_data_o = tgt_data_q;
endmodule

// File: rtl/nfc_status.sv
module nfc_status
  import nfc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SECT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              re_i,
  input  nfc_state_e        st_i,
  input  logic [SECT_W-1:0] rd_sect_i,
  input  logic [SECT_W-1:0] tgt_sect_i,
  input  logic              tgt_msb_i,
  input  logic [DATA_W-1:0] arr_data_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic tog6_q, tog2_q, stat_sel, erasing;
  logic [DATA_W-1:0] stat;

  assign erasing  = (st_i == ST_ERASE);
  assign stat_sel = (st_i == ST_PROG) || (st_i == ST_PSETTLE) || erasing ||
                    ((st_i == ST_PSUSP) && (rd_sect_i == tgt_sect_i));

  always_comb begin
    stat    = '0;
    stat[7] = erasing ? 1'b0 : ~tgt_msb_i;
    stat[6] = tog6_q;
    stat[2] = tog2_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      tog6_q  <= 1'b0;
      tog2_q  <= 1'b0;
    end else if (re_i) begin
      rdata_o <= stat_sel ? stat : arr_data_i;
      if (stat_sel)            tog6_q <= ~tog6_q;
      if (stat_sel && erasing) tog2_q <= ~tog2_q;
    end
  end
endmodule

// File: rtl/norflash_cmd_fsm.sv
module norflash_cmd_fsm
  import nfc_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int DATA_W    = 8,
  parameter int IDX_W     = 4,
  parameter int SECT_SH   = 2,
  parameter int PROG_CYC  = 20,
  parameter int ERASE_CYC = 60,
  parameter int SUSP_CYC  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              ready_o
);
  localparam int MAX_OP  = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int MAX_CYC = (MAX_OP > SUSP_CYC) ? MAX_OP : SUSP_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam int SECT_W  = IDX_W - SECT_SH;

  nfc_state_e st;
  logic op_load, settle_load, op_done, settle_done, prog_we, erase_all;
  logic [CNT_W-1:0]  op_len, settle_len;
  logic [IDX_W-1:0]  tgt_idx;
  logic [DATA_W-1:0] tgt_data, arr_data;

  nfc_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .CNT_W(CNT_W),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .SUSP_CYC(SUSP_CYC)
  ) u_ctrl (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .op_done_i(op_done), .settle_done_i(settle_done),
    .st_o(st), .op_load_o(op_load), .op_len_o(op_len),
    .settle_load_o(settle_load), .settle_len_o(settle_len),
    .prog_we_o(prog_we), .erase_all_o(erase_all),
    .tgt_idx_o(tgt_idx), .tgt_data_o(tgt_data)
  );

  nfc_cnt #(.CNT_W(CNT_W)) u_op_cnt (
    .clk_i, .rst_ni, .load_i(op_load), .load_val_i(op_len),
    .run_i((st == ST_PROG) || (st == ST_ERASE)), .done_o(op_done)
  );

  nfc_cnt #(.CNT_W(CNT_W)) u_settle_cnt (
    .clk_i, .rst_ni, .load_i(settle_load), .load_val_i(settle_len),
    .run_i(st == ST_PSETTLE), .done_o(settle_done)
  );

  nfc_array #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_array (
    .clk_i, .erase_all_i(erase_all), .prog_we_i(prog_we),
    .wr_idx_i(tgt_idx), .wr_data_i(tgt_data),
    .rd_idx_i(addr_i[IDX_W-1:0]), .rd_data_o(arr_data)
  );

  nfc_status #(.DATA_W(DATA_W), .SECT_W(SECT_W)) u_status (
    .clk_i, .rst_ni, .re_i, .st_i(st),
    .rd_sect_i(addr_i[IDX_W-1:SECT_SH]), .tgt_sect_i(tgt_idx[IDX_W-1:SECT_SH]),
    .tgt_msb_i(tgt_data[7]), .arr_data_i(arr_data), .rdata_o
  );

  assign ready_o = !((st == ST_PROG) || (st == ST_PSETTLE) || (st == ST_ERASE));
endmodule

// File: rtl/norflash_cmd_fsm_chk.sv
module norflash_cmd_fsm_chk
  import nfc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic              ready_o,
  input nfc_state_e        st,
  input logic              op_done
);
  // R2
  busy_needs_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |-> $past(we_i));

  // R6
  erase_ignores_writes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_ERASE && we_i && !op_done) |=> (st == ST_ERASE && !ready_o));

  // R9
  suspend_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_PROG && we_i && wdata_i == DATA_W'(CMD_SUSP) && !op_done) |=> (st == ST_PSETTLE));

  // R9
  suspended_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_PSUSP) |-> ready_o);

  // R11
  resume_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st == ST_PSUSP && we_i && wdata_i == DATA_W'(CMD_RESUME)) |=> !ready_o);
endmodule

bind norflash_cmd_fsm norflash_cmd_fsm_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .wdata_i(wdata_i),
  .ready_o(ready_o), .st(st), .op_done(op_done)
);

// File: tb/norflash_cmd_fsm_tb.sv
module norflash_cmd_fsm_tb;
  localparam int ADDR_W = 12, DATA_W = 8, IDX_W = 4, SECT_SH = 2;
  localparam int PROG_CYC = 20, ERASE_CYC = 60, SUSP_CYC = 8;
  localparam int WORDS = 1 << IDX_W;

  logic clk = 1'b0, rst_n = 1'b0, we = 1'b0, re = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic ready;

  int checks = 0, failures = 0, busy_cnt = 0;
  logic [7:0] mdl [WORDS];

  always #4 clk = ~clk;

  norflash_cmd_fsm #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W), .SECT_SH(SECT_SH),
    .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .SUSP_CYC(SUSP_CYC)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .re_i(re), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .ready_o(ready)
  );

  always @(negedge clk) if (rst_n && !ready) busy_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    we = 1'b1; addr = ADDR_W'(a); wdata = DATA_W'(d);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    re = 1'b1; addr = ADDR_W'(a);
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic wait_ready();
    int n = 0;
    while (!ready && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic start_prog(input int idx, input int d);
    wr(32'h555, 32'hAA); wr(32'h2AA, 32'h55); wr(32'h555, 32'hA0); wr(idx, d);
  endtask

  task automatic start_erase();
    wr(32'h555, 32'hAA); wr(32'h2AA, 32'h55); wr(32'h555, 32'h80);
    wr(32'h555, 32'hAA); wr(32'h2AA, 32'h55); wr(32'h555, 32'h10);
  endtask

  task automatic check_all(input string req);
    logic [7:0] v;
    for (int i = 0; i < WORDS; i++) begin
      rd(i, v);
      chk(v === mdl[i], req, int'(v), int'(mdl[i]));
    end
  endtask

  task automatic run_prog(input int idx, input int d, input string req);
    logic [7:0] v;
    busy_cnt = 0;
    start_prog(idx, d);
    wait_ready();
    mdl[idx] = mdl[idx] & 8'(d);
    chk(busy_cnt == PROG_CYC, "R2 busy", busy_cnt, PROG_CYC);
    rd(idx, v);
    chk(v === mdl[idx], req, int'(v), int'(mdl[idx]));
  endtask

  initial begin
    logic [7:0] s1, s2, v;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(ready === 1'b1, "R1 ready in reset", int'(ready), 1);
    chk(rdata === 8'h00, "R1 rdata in reset", int'(rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4 chip erase
    busy_cnt = 0;
    start_erase();
    wait_ready();
    chk(busy_cnt == ERASE_CYC, "R4 erase busy", busy_cnt, ERASE_CYC);
    for (int i = 0; i < WORDS; i++) mdl[i] = 8'hFF;
    check_all("R4 erased word");

    // R2 R3 directed program and AND behaviour
    run_prog(3, 32'h5A, "R3 program 5A");
    run_prog(3, 32'h0F, "R3 program AND");
    // R12 immediate data after strobe edge
    rd(3, v);
    chk(v === 8'h0A, "R12 read latency", int'(v), 8'h0A);

    // R7 R8 status during program
    busy_cnt = 0;
    start_prog(6, 32'h93);
    rd(6, s1); rd(1, s2);
    chk(s1[7] == 1'b0 && s2[7] == 1'b0, "R7 prog bit7", int'(s1), 32'h00);
    chk((s1 & 8'h3B) == 0 && (s2 & 8'h3B) == 0, "R7 other bits zero", int'(s1 | s2), 0);
    chk(s1[6] != s2[6], "R8 bit6 toggles prog", int'(s2), int'(s1 ^ 8'h40));
    chk(s1[2] == s2[2], "R8 bit2 holds prog", int'(s2), int'(s1));
    wait_ready();
    mdl[6] = mdl[6] & 8'h93;
    chk(busy_cnt == PROG_CYC, "R2 busy with reads", busy_cnt, PROG_CYC);
    busy_cnt = 0;
    start_prog(7, 32'h11);
    rd(7, s1);
    chk(s1[7] == 1'b1, "R7 prog bit7 inverse", int'(s1[7]), 1);
    wait_ready();
    mdl[7] = mdl[7] & 8'h11;

    // R6 R7 R8 status and ignored writes during erase
    busy_cnt = 0;
    start_erase();
    rd(9, s1); rd(2, s2);
    chk(s1[7] == 1'b0, "R7 erase bit7", int'(s1), 0);
    chk(s1[6] != s2[6], "R8 bit6 toggles erase", int'(s2), int'(s1 ^ 8'h40));
    chk(s1[2] != s2[2], "R8 bit2 toggles erase", int'(s2), int'(s1 ^ 8'h04));
    wr(32'h555, 32'hAA); wr(32'h0, 32'hB0); wr(32'h2AA, 32'h55); wr(32'h4, 32'h30);
    chk(ready === 1'b0, "R6 suspend ignored in erase", int'(ready), 0);
    wait_ready();
    chk(busy_cnt == ERASE_CYC, "R6 erase length", busy_cnt, ERASE_CYC);
    for (int i = 0; i < WORDS; i++) mdl[i] = 8'hFF;
    check_all("R6 erase result");

    // R9 R10 R11 suspend / resume
    run_prog(9, 32'hC3, "R3 neighbour program");
    busy_cnt = 0;
    start_prog(5, 32'h3C);
    repeat (4) @(negedge clk);
    wr(32'h7FF, 32'hB0);
    chk(ready === 1'b0, "R9 settling busy", int'(ready), 0);
    wait_ready();
    repeat (5) @(negedge clk);
    chk(ready === 1'b1, "R9 suspended ready", int'(ready), 1);
    rd(5, v);
    chk(v[7] == 1'b1 && (v & 8'h3B) == 0, "R10 target sector status", int'(v), 32'h80);
    rd(6, v);
    chk(v[7] == 1'b1, "R10 same sector status", int'(v[7]), 1);
    rd(9, v);
    chk(v === 8'hC3, "R10 other sector data", int'(v), 8'hC3);
    wr(32'h123, 32'h30);
    wait_ready();
    mdl[5] = 8'h3C;
    chk(busy_cnt == PROG_CYC + SUSP_CYC, "R11 total busy", busy_cnt, PROG_CYC + SUSP_CYC);
    rd(5, v);
    chk(v === 8'h3C, "R11 resumed result", int'(v), 8'h3C);

    // R11 extra resume ignored, second suspend
    busy_cnt = 0;
    start_prog(10, 32'h66);
    wr(32'h0, 32'hB0);
    wait_ready();
    wr(32'h0, 32'h30);
    wr(32'h0, 32'h30);
    chk(ready === 1'b0, "R11 extra resume ignored", int'(ready), 0);
    wr(32'h0, 32'hB0);
    wait_ready();
    chk(ready === 1'b1, "R11 second suspend", int'(ready), 1);
    rd(10, v);
    chk(v[7] == 1'b1, "R11 still suspended status", int'(v[7]), 1);
    wr(32'h0, 32'h30);
    wait_ready();
    mdl[10] = 8'h66;
    chk(busy_cnt == PROG_CYC + 2 * SUSP_CYC, "R11 two suspends busy", busy_cnt,
        PROG_CYC + 2 * SUSP_CYC);
    rd(10, v);
    chk(v === 8'h66, "R11 data after two suspends", int'(v), 8'h66);

    // R5 directed mismatches
    busy_cnt = 0;
    wr(32'h555, 32'hAA); wr(32'h2AB, 32'h55); wr(32'h555, 32'hA0); wr(32'h1, 32'h00);
    repeat (3) @(negedge clk);
    chk(busy_cnt == 0, "R5 bad unlock address", busy_cnt, 0);
    wr(32'h555, 32'hAA); wr(32'h2AA, 32'h55); wr(32'h555, 32'h80);
    wr(32'h555, 32'hAA); wr(32'h2AA, 32'h55); wr(32'h555, 32'h30);
    wr(32'h2, 32'h00);
    repeat (3) @(negedge clk);
    chk(busy_cnt == 0, "R5 bad erase command", busy_cnt, 0);
    // R5 random writes that never hit the first unlock address
    for (int i = 0; i < 40; i++) begin
      int a = int'($urandom_range(0, 32'hFFF));
      if (a == 32'h555) a = 32'h554;
      wr(a, int'($urandom_range(0, 255)));
    end
    repeat (2) @(negedge clk);
    chk(busy_cnt == 0, "R5 random writes", busy_cnt, 0);
    check_all("R5 array unchanged");

    // R2 R3 random programs
    for (int i = 0; i < 30; i++)
      run_prog(int'($urandom_range(0, WORDS - 1)), int'($urandom_range(0, 255)), "R3 random program");

    // R1 reset aborts erase
    start_erase();
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(ready === 1'b1, "R1 reset aborts erase", int'(ready), 1);
    chk(rdata === 8'h00, "R1 rdata after reset", int'(rdata), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 array kept after abort");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule